// File: doc/BRIEF.md
# Multi-Operand Compressor-Tree Adder

This block adds N unsigned operands of W bits each and returns their exact sum. The operands arrive together on one wide bus, qualified by a valid flag. Inside, the bits are treated as columns of equal weight. A fixed series of reduction stages shrinks those columns. Each stage places small counters of up to six inputs. A counter may take bits from one column alone, or from one column and the column above it. Each counter emits a short binary count that lands in the columns of matching weight in the next stage.

The counter layout is decided when the design is elaborated. Within a stage, the tallest uncovered column is served first. Counters that compress more input bits per output bit are preferred. Bits left uncovered pass straight through to the same column. Stages are added until no column holds more than three bits. A single three-input carry-propagate add then produces the result.

A parameter inserts a register after every reduction stage. The valid flag is carried alongside the data through these registers. The result always leaves through an output register. The block accepts a new operand set on every clock cycle.

Top module: `mosum_gpc_tree`

## Requirements
- R1: When out_valid is high, out_sum equals the unsigned sum of the N operands of the matching accepted input set. Operand i occupies in_ops bits [i*W+W-1 : i*W].
- R2: out_sum is W + ceil(log2(N)) bits wide and never overflows. With every operand at 2^W-1, the result is exactly N*(2^W-1).
- R3: A new operand set may be presented on every cycle with in_valid high. Results appear back to back, in the order the sets were accepted.
- R4: With PIPE=1, the latency from accepting a set to out_valid is the number of reduction stages plus one. For the default N=8, W=8, the reduction takes two stages, so the latency is 3 cycles.
- R5: With PIPE=0, the whole reduction and the final add are combinational in front of the output register, so the latency is 1 cycle.
- R6: out_valid is high for exactly one cycle per accepted set, and never for a cycle on which in_valid was low.
- R7: While out_valid is low, out_sum keeps its previous value, whatever is on in_ops.
- R8: While rst_n is low, out_valid is 0 and out_sum is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand bus holds a set to add this cycle |
| in_ops | input | N*W | N packed unsigned operands, operand 0 in the low bits |
| out_valid | output | 1 | out_sum holds a new result this cycle |
| out_sum | output | W+ceil(log2(N)) | Sum of the operand set |

## Verification
The hardest cases to reach are counters that straddle two columns and carries that land two columns higher in the top columns of the result. Random operands seldom fill the upper columns densely enough to drive those paths to their limits. The stimulus therefore adds all-ones sets, which produce the maximum sum. It also walks a full-scale value through each operand position, and walks a single set bit through every column in all operands at once. These run alongside back-to-back random sets. Idle gaps carry junk operands with in_valid low, to show that the output holds.

// File: rtl/gpc_tree_pkg.sv
package gpc_tree_pkg;

    localparam int MAX_COLS  = 64;
    localparam int STAGE_CAP = 24;

    localparam int PROBE_HEIGHT = 0;
    localparam int PROBE_STAGES = 1;
    localparam int PROBE_HMAX   = 2;

    // Counter shapes: (bits of weight 2, bits of weight 1 ; outputs)
    typedef enum logic [2:0] {
        CK_NONE,
        CK_15,   // (1,5;3)
        CK_06,   // (0,6;3)
        CK_23,   // (2,3;3)
        CK_14,   // (1,4;3)
        CK_05,   // (0,5;3)
        CK_04,   // (0,4;3)
        CK_03    // (0,3;2)
    } ctr_kind_e;

    // Preference by compression ratio, given bits left in the column and the one above
    function automatic ctr_kind_e pick_ctr(input int lo, input int hi);
        if (lo >= 5 && hi >= 1)      return CK_15;
        else if (lo >= 6)            return CK_06;
        else if (lo >= 3 && hi >= 2) return CK_23;
        else if (lo >= 4 && hi >= 1) return CK_14;
        else if (lo >= 5)            return CK_05;
        else if (lo == 4)            return CK_04;
        else if (lo == 3)            return CK_03;
        else                         return CK_NONE;
    endfunction

    function automatic int ctr_lo(input ctr_kind_e k);
        case (k)
            CK_15, CK_05: return 5;
            CK_06:        return 6;
            CK_14, CK_04: return 4;
            CK_23, CK_03: return 3;
            default:      return 0;
        endcase
    endfunction

    function automatic int ctr_hi(input ctr_kind_e k);
        case (k)
            CK_15, CK_14: return 1;
            CK_23:        return 2;
            default:      return 0;
        endcase
    endfunction

    function automatic int ctr_nout(input ctr_kind_e k);
        case (k)
            CK_NONE: return 0;
            CK_03:   return 2;
            default: return 3;
        endcase
    endfunction

    // Replays the placement on column heights only.
    function automatic int tree_probe(input int n, input int w, input int stg,
                                      input int col, input int mode);
        int h   [MAX_COLS];
        int rem [MAX_COLS];
        int nh  [MAX_COLS];
        int cols, hmax, mx, best, bh, hi_av;
        bit done;
        ctr_kind_e k;
        cols = w + $clog2(n);
        hmax = n;
        for (int c = 0; c < MAX_COLS; c++) h[c] = (c < w) ? n : 0;
        for (int s = 0; s < STAGE_CAP; s++) begin
            if (mode == PROBE_HEIGHT && s == stg) return h[col];
            mx = 0;
            for (int c = 0; c < cols; c++) if (h[c] > mx) mx = h[c];
            if (mx <= 3) begin
                if (mode == PROBE_STAGES) return s;
                if (mode == PROBE_HMAX)   return hmax;
                return 0;
            end
            for (int c = 0; c < MAX_COLS; c++) begin
                rem[c] = h[c];
                nh[c]  = 0;
            end
            done = 1'b0;
            for (int it = 0; it < cols * n; it++) begin
                if (!done) begin
                    best = -1;
                    bh   = 2;
                    for (int c = 0; c < cols; c++)
                        if (rem[c] > bh) begin
                            bh   = rem[c];
                            best = c;
                        end
                    if (best < 0) done = 1'b1;
                    else begin
                        hi_av = (best + 1 < cols) ? rem[best+1] : 0;
                        k = pick_ctr(rem[best], hi_av);
                        rem[best] -= ctr_lo(k);
                        if (best + 1 < cols) rem[best+1] -= ctr_hi(k);
                        for (int j = 0; j < ctr_nout(k); j++)
                            if (best + j < cols) nh[best+j]++;
                    end
                end
            end
            for (int c = 0; c < MAX_COLS; c++) begin
                h[c] = nh[c] + rem[c];
                if (h[c] > hmax) hmax = h[c];
            end
        end
        return -1;
    endfunction

endpackage

// File: rtl/gpc_stage.sv
module gpc_stage
    import gpc_tree_pkg::*;
#(
    parameter int N    = 8,
    parameter int W    = 8,
    parameter int COLS = 11,
    parameter int HMAX = 8,
    parameter int STG  = 0
) (
    input  logic [COLS-1:0][HMAX-1:0] bits_i,
    output logic [COLS-1:0][HMAX-1:0] bits_o
);

    localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int HW   = (HMAX > 1) ? $clog2(HMAX) : 1;
    localparam int ITER = COLS * N;

    int hin [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_height
        localparam int HC = tree_probe(N, W, STG, c, PROBE_HEIGHT);
        assign hin[c] = HC;
    end

    always_comb begin
        int rem  [COLS];
        int used [COLS];
        int fill [COLS];
        int best, bh, hi_av, val, tgt;
        bit done;
        ctr_kind_e k;
        logic [CW-1:0] ci;
        logic [HW-1:0] si;
        logic [2:0] v3, v3s;

        bits_o = '0;
        best = 0; bh = 0; hi_av = 0; val = 0; tgt = 0;
        k = CK_NONE; ci = '0; si = '0; v3 = '0; v3s = '0;
        for (int c = 0; c < COLS; c++) begin
            rem[c]  = hin[c];
            used[c] = 0;
            fill[c] = 0;
        end
        done = 1'b0;

        // counters, tallest uncovered column first
        for (int it = 0; it < ITER; it++) begin
            if (!done) begin
                best = -1;
                bh   = 2;
                for (int c = 0; c < COLS; c++)
                    if (rem[c] > bh) begin
                        bh   = rem[c];
                        best = c;
                    end
                if (best < 0) done = 1'b1;
                else begin
                    hi_av = (best + 1 < COLS) ? rem[best+1] : 0;
                    k     = pick_ctr(rem[best], hi_av);
                    val   = 0;
                    ci    = CW'(best);
                    for (int j = 0; j < ctr_lo(k); j++) begin
                        si  = HW'(used[best] + j);
                        val = val + int'(bits_i[ci][si]);
                    end
                    used[best] += ctr_lo(k);
                    rem[best]  -= ctr_lo(k);
                    if (best + 1 < COLS) begin
                        ci = CW'(best + 1);
                        for (int j = 0; j < ctr_hi(k); j++) begin
                            si  = HW'(used[best+1] + j);
                            val = val + 2 * int'(bits_i[ci][si]);
                        end
                        used[best+1] += ctr_hi(k);
                        rem[best+1]  -= ctr_hi(k);
                    end
                    v3 = 3'(val);
                    for (int j = 0; j < ctr_nout(k); j++) begin
                        tgt = best + j;
                        if (tgt < COLS) begin
                            v3s = v3 >> j;
                            ci  = CW'(tgt);
                            si  = HW'(fill[tgt]);
                            bits_o[ci][si] = v3s[0];
                            fill[tgt]++;
                        end
                    end
                end
            end
        end

        // uncovered bits keep their column
        for (int c = 0; c < COLS; c++) begin
            for (int s = 0; s < HMAX; s++) begin
                if (s >= used[c] && s < hin[c]) begin
                    ci = CW'(c);
                    si = HW'(s);
                    v3s[0] = bits_i[ci][si];
                    si = HW'(fill[c]);
                    bits_o[ci][si] = v3s[0];
                    fill[c]++;
                end
            end
        end
    end

endmodule

// File: rtl/gpc_pipe_reg.sv
module gpc_pipe_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [DW-1:0] dat_i,
    output logic          vld_o,
    output logic [DW-1:0] dat_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            dat_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) dat_o <= dat_i;
        end
    end

endmodule

// File: rtl/gpc_ternary_add.sv
module gpc_ternary_add #(
    parameter int COLS = 11,
    parameter int HMAX = 8
) (
    input  logic [COLS-1:0][HMAX-1:0] bits_i,
    output logic [COLS-1:0]           sum_o
);

    logic [COLS-1:0] row_a, row_b, row_c;

    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            row_a[c] = bits_i[c][0];
            row_b[c] = bits_i[c][1];
            row_c[c] = bits_i[c][2];
        end
    end

    // slots above the third are empty once reduction ends
    if (HMAX > 3) begin : g_spare
        logic [COLS-1:0] unused_slots;
        always_comb
            for (int c = 0; c < COLS; c++) unused_slots[c] = ^bits_i[c][HMAX-1:3];
    end

    assign sum_o = row_a + row_b + row_c;

endmodule

// File: rtl/mosum_gpc_tree.sv
module mosum_gpc_tree
    import gpc_tree_pkg::*;
#(
    parameter  int N    = 8,
    parameter  int W    = 8,
    parameter  int PIPE = 1,
    localparam int SW   = W + $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [N*W-1:0]  in_ops,
    output logic            out_valid,
    output logic [SW-1:0]   out_sum
);

    localparam int COLS = SW;
    localparam int NSTG = tree_probe(N, W, 0, 0, PROBE_STAGES);
    localparam int HMAX = tree_probe(N, W, 0, 0, PROBE_HMAX);

    logic [COLS-1:0][HMAX-1:0] lvl [NSTG+1];
    logic [COLS-1:0][HMAX-1:0] red [NSTG];
    logic                      vld [NSTG+1];
    logic [COLS-1:0][HMAX-1:0] lvl0;
    logic [COLS-1:0]           tsum;

    always_comb begin
        lvl0 = '0;
        for (int c = 0; c < W; c++)
            for (int i = 0; i < N; i++)
                lvl0[c][i] = in_ops[i*W + c];
    end

    assign lvl[0] = lvl0;
    assign vld[0] = in_valid;

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        gpc_stage #(
            .N(N), .W(W), .COLS(COLS), .HMAX(HMAX), .STG(s)
        ) u_stage (
            .bits_i (lvl[s]),
            .bits_o (red[s])
        );
        if (PIPE != 0) begin : g_reg
            gpc_pipe_reg #(.DW(COLS*HMAX)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .vld_i (vld[s]),
                .dat_i (red[s]),
                .vld_o (vld[s+1]),
                .dat_o (lvl[s+1])
            );
        end else begin : g_wire
            assign lvl[s+1] = red[s];
            assign vld[s+1] = vld[s];
        end
    end

    gpc_ternary_add #(.COLS(COLS), .HMAX(HMAX)) u_final (
        .bits_i (lvl[NSTG]),
        .sum_o  (tsum)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= vld[NSTG];
            if (vld[NSTG]) out_sum <= tsum;
        end
    end

endmodule

// File: rtl/gpc_tree_chk.sv
module gpc_tree_chk
    import gpc_tree_pkg::*;
#(
    parameter  int N    = 8,
    parameter  int W    = 8,
    parameter  int PIPE = 1,
    localparam int SW   = W + $clog2(N)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N*W-1:0] in_ops,
    input logic           out_valid,
    input logic [SW-1:0]  out_sum
);

    localparam int    NSTG = tree_probe(N, W, 0, 0, PROBE_STAGES);
    localparam int    LAT  = (PIPE != 0) ? NSTG + 1 : 1;
    localparam longint MAXV = longint'(N) * ((longint'(1) << W) - 1);

    logic [SW-1:0] ref_now;
    logic [SW-1:0] ref_q [LAT];
    logic          vq    [LAT];

    always_comb begin
        ref_now = '0;
        for (int i = 0; i < N; i++) ref_now = ref_now + SW'(in_ops[i*W +: W]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                vq[i]    <= 1'b0;
                ref_q[i] <= '0;
            end
        end else begin
            vq[0]    <= in_valid;
            ref_q[0] <= ref_now;
            for (int i = 1; i < LAT; i++) begin
                vq[i]    <= vq[i-1];
                ref_q[i] <= ref_q[i-1];
            end
        end
    end

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum == ref_q[LAT-1]);  // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> longint'(out_sum) <= MAXV);  // R2

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vq[LAT-1]);  // R4, R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sum));  // R7

endmodule

bind mosum_gpc_tree gpc_tree_chk #(.N(N), .W(W), .PIPE(PIPE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ops    (in_ops),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/tb_mosum_gpc_tree.sv
module tb_mosum_gpc_tree;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int W   = 8;
    localparam int SW  = 11;
    localparam int LAT = 3;
    localparam int N2  = 5;
    localparam int W2  = 4;
    localparam int SW2 = 7;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, out_valid;
    logic [N*W-1:0] in_ops;
    logic [SW-1:0]  out_sum;
    logic in_valid2, out_valid2;
    logic [N2*W2-1:0] in_ops2;
    logic [SW2-1:0]   out_sum2;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    logic [SW-1:0] last_sum;

    typedef struct {
        longint s;
        int     t;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mosum_gpc_tree #(.N(N), .W(W), .PIPE(1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ops(in_ops),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    mosum_gpc_tree #(.N(N2), .W(W2), .PIPE(0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid2), .in_ops(in_ops2),
        .out_valid(out_valid2), .out_sum(out_sum2)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic send(input logic [N*W-1:0] ops);
        exp_t e;
        longint s;
        s = 0;
        for (int i = 0; i < N; i++) s += longint'(ops[i*W +: W]);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_ops   = ops;
        e.s = s;
        e.t = cyc;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_ops   = {$urandom, $urandom};
        end
    endtask

    task automatic send2(input logic [N2*W2-1:0] ops);
        longint s;
        s = 0;
        for (int i = 0; i < N2; i++) s += longint'(ops[i*W2 +: W2]);
        @(posedge clk); #1;
        in_valid2 = 1'b1;
        in_ops2   = ops;
        @(posedge clk); #1;
        in_valid2 = 1'b0;
        in_ops2   = N2*W2'($urandom);
        @(negedge clk);
        chk(out_valid2 == 1'b1, "R5 one-cycle valid", longint'(out_valid2), 1);
        chk(longint'(out_sum2) == s, "R5 R1 comb sum", longint'(out_sum2), s);
        @(negedge clk);
        chk(out_valid2 == 1'b0, "R6 single pulse", longint'(out_valid2), 0);
        chk(longint'(out_sum2) == s, "R7 hold comb", longint'(out_sum2), s);
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (out_valid) begin
                    if (q.size() == 0) chk(1'b0, "R6 unexpected valid", 1, 0);
                    else begin
                        e = q.pop_front();
                        chk(longint'(out_sum) == e.s, "R1 R3 sum", longint'(out_sum), e.s);
                        chk(cyc - e.t == LAT, "R4 latency", cyc - e.t, LAT);
                    end
                    last_sum = out_sum;
                end else begin
                    chk(out_sum == last_sum, "R7 hold", longint'(out_sum), longint'(last_sum));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [N*W-1:0] ops;
        rst_n = 1'b0;
        in_valid = 1'b0; in_ops = '1;
        in_valid2 = 1'b0; in_ops2 = '1;
        last_sum = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset valid", longint'(out_valid), 0);
        chk(out_sum == '0, "R8 reset sum", longint'(out_sum), 0);
        chk(out_valid2 == 1'b0, "R8 reset valid comb", longint'(out_valid2), 0);
        chk(out_sum2 == '0, "R8 reset sum comb", longint'(out_sum2), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_on = 1'b1;

        // extremes (R2)
        send('0);
        send('1);
        idle(2);
        send('1);
        idle(4);
        // full-scale value walked through each operand slot
        for (int i = 0; i < N; i++) begin
            ops = '0;
            ops[i*W +: W] = '1;
            send(ops);
        end
        // one bit walked through every column of all operands
        for (int b = 0; b < W; b++) begin
            ops = '0;
            for (int i = 0; i < N; i++) ops[i*W + b] = 1'b1;
            send(ops);
        end
        // alternating patterns
        send({(N*W/8){8'hAA}});
        send({(N*W/8){8'h55}});
        // back-to-back random (R3)
        for (int k = 0; k < 60; k++) send({$urandom, $urandom});
        // sparse random with junk in gaps (R6, R7)
        for (int k = 0; k < 30; k++) begin
            send({$urandom, $urandom});
            idle(1 + ($urandom % 4));
        end
        idle(LAT + 4);
        chk(q.size() == 0, "R6 all results seen", q.size(), 0);

        // combinational-reduction variant (R5)
        send2('0);
        send2('1);
        for (int k = 0; k < 12; k++) send2(N2*W2'($urandom));

        finish_run();
    end

endmodule